// File: doc/BRIEF.md
# Serial Multi-Byte Magnitude Comparator

This block orders two integers that are too wide to present at once. The integers arrive as a stream of byte pairs, one pair per accepted cycle, starting with the most significant pair. A start pulse opens a comparison. It sets how many bytes each operand has, from 1 up to a parameter limit, and whether the operands are two's complement or plain binary. Byte pairs are then offered with a valid strobe, and gaps between them are allowed.

Only the leading pair can carry a sign. For that reason the signed rule applies to the first pair alone. Every later pair is ordered as unsigned magnitudes, and a later pair counts only when all earlier pairs matched. When the order is known, the block raises `done_o`, and exactly one of `gt_o`, `eq_o` or `lt_o` goes high. A mismatch ends the comparison at once, and any remaining pairs of that transfer are ignored. The result holds until the next start pulse. A new start pulse also abandons any comparison that is still running.

Top module: `serial_mag_cmp`

## Requirements
- R1: The first pair accepted after a start is the most significant one, and a difference in it decides the result whatever the later pairs hold.
- R2: With `signed_i` set at start, the first pair is ordered as two's complement bytes (for example 0x7F is greater than 0x80).
- R3: Every pair after the first is ordered as unsigned bytes, even in signed mode, and it matters only when all earlier pairs were equal.
- R4: While `done_o` is low, `gt_o`, `eq_o` and `lt_o` are all 0. While `done_o` is high, exactly one of them is 1.
- R5: When an accepted pair differs, `done_o` rises on the next clock edge. Pairs offered after that have no effect on any output.
- R6: When all N pairs match, `done_o` rises with `eq_o` on the edge that follows the N-th accepted pair, and not before.
- R7: A start pulse clears `done_o` and the result flags on the next edge and drops any comparison in progress. A pair offered in the same cycle as start is not consumed.
- R8: After `done_o` rises, `done_o` and the flags keep their values until the next start pulse.
- R9: A byte count of 0 at start is taken as 1. A count above MAX_BYTES (default 8) is taken as MAX_BYTES.
- R10: With `signed_i` clear, the whole operand is ordered as an unsigned number (for example 0x80000000 is greater than 0x7FFFFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a new comparison (aborts any current one) |
| nbytes_i | input | CNT_W (4) | Byte count per operand, sampled with start |
| signed_i | input | 1 | Two's complement mode, sampled with start |
| valid_i | input | 1 | A byte pair is offered this cycle |
| a_i | input | BYTE_W (8) | Byte of operand A |
| b_i | input | BYTE_W (8) | Byte of operand B |
| done_o | output | 1 | Result is resolved |
| gt_o | output | 1 | A greater than B |
| eq_o | output | 1 | A equal to B |
| lt_o | output | 1 | A less than B |

## Verification
The bench uses operand pairs that give different answers under the signed and unsigned rules. This tells the two modes apart on the same bit patterns. Other pairs match in the top byte but differ in a lower byte whose sign bit is set, which shows whether the lower bytes are wrongly compared as signed. A mismatch in the top byte with opposite-ordered lower bytes checks that the top byte decides. All-equal 8-byte operands, sent with gaps, check that the equal result appears only after the last pair. Trailing mismatched pairs, a start during a live comparison, and out-of-range byte counts check that ignored input really has no effect.

// File: rtl/smc_pkg.sv
package smc_pkg;
   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_GT = 2'd1,
      REL_LT = 2'd2
   } rel_e;
endpackage

// File: rtl/smc_byte_rel.sv
module smc_byte_rel
   import smc_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter bit SIGN_BY_FLIP = 1'b1
) (
   input  logic [BYTE_W-1:0] a,
   input  logic [BYTE_W-1:0] b,
   input  logic              as_signed,
   output rel_e              rel
);
   localparam int MSB = BYTE_W - 1;

   logic a_gt, a_lt;

   generate
      if (SIGN_BY_FLIP) begin : g_flip
         // invert the sign bit so one unsigned comparator serves both modes
         logic [BYTE_W-1:0] ka, kb;
         always_comb begin
            ka = a;
            kb = b;
            ka[MSB] = a[MSB] ^ as_signed;
            kb[MSB] = b[MSB] ^ as_signed;
            a_gt = ka > kb;
            a_lt = ka < kb;
         end
      end else begin : g_dual
         always_comb begin
            if (as_signed) begin
               a_gt = $signed(a) > $signed(b);
               a_lt = $signed(a) < $signed(b);
            end else begin
               a_gt = a > b;
               a_lt = a < b;
            end
         end
      end
   endgenerate

   always_comb begin
      if (a_gt)      rel = REL_GT;
      else if (a_lt) rel = REL_LT;
      else           rel = REL_EQ;
   end
endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl #(
   parameter int MAX_BYTES = 8,
   parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] nbytes,
   input  logic             sgn_mode,
   input  logic             valid,
   input  logic             differs,
   output logic             take,
   output logic             last,
   output logic             sign_now
);
   localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);
   localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

   logic [CNT_W-1:0] left_q;
   logic             first_q, busy_q, sgn_q;
   logic [CNT_W-1:0] load_cnt;

   always_comb begin
      if (nbytes == '0)          load_cnt = ONE_CNT;
      else if (nbytes > MAX_CNT) load_cnt = MAX_CNT;
      else                       load_cnt = nbytes;
   end

   assign take     = busy_q & valid & ~start;
   assign last     = (left_q == ONE_CNT);
   assign sign_now = sgn_q & first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         first_q <= 1'b0;
         busy_q  <= 1'b0;
         sgn_q   <= 1'b0;
      end else if (start) begin
         left_q  <= load_cnt;
         first_q <= 1'b1;
         busy_q  <= 1'b1;
         sgn_q   <= sgn_mode;
      end else if (take) begin
         if (differs || last) begin
            busy_q <= 1'b0;
         end else begin
            left_q  <= left_q - ONE_CNT;
            first_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/serial_mag_cmp.sv
module serial_mag_cmp
   import smc_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter int MAX_BYTES    = 8,
   parameter bit SIGN_BY_FLIP = 1'b1,
   parameter int CNT_W        = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  nbytes_i,
   input  logic              signed_i,
   input  logic              valid_i,
   input  logic [BYTE_W-1:0] a_i,
   input  logic [BYTE_W-1:0] b_i,
   output logic              done_o,
   output logic              gt_o,
   output logic              eq_o,
   output logic              lt_o
);
   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("serial_mag_cmp: BYTE_W must be at least 2");
      end
      if (MAX_BYTES < 1) begin : g_bad_depth
         $error("serial_mag_cmp: MAX_BYTES must be at least 1");
      end
      if (CNT_W < $clog2(MAX_BYTES + 1)) begin : g_bad_cnt
         $error("serial_mag_cmp: CNT_W too narrow for MAX_BYTES");
      end
   endgenerate

   rel_e rel;
   logic take, last, sign_now;
   logic differs;

   assign differs = (rel != REL_EQ);

   smc_byte_rel #(
      .BYTE_W      (BYTE_W),
      .SIGN_BY_FLIP(SIGN_BY_FLIP)
   ) u_rel (
      .a        (a_i),
      .b        (b_i),
      .as_signed(sign_now),
      .rel      (rel)
   );

   smc_ctrl #(
      .MAX_BYTES(MAX_BYTES),
      .CNT_W    (CNT_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_i),
      .nbytes  (nbytes_i),
      .sgn_mode(signed_i),
      .valid   (valid_i),
      .differs (differs),
      .take    (take),
      .last    (last),
      .sign_now(sign_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         gt_o   <= 1'b0;
         eq_o   <= 1'b0;
         lt_o   <= 1'b0;
      end else if (start_i) begin
         done_o <= 1'b0;
         gt_o   <= 1'b0;
         eq_o   <= 1'b0;
         lt_o   <= 1'b0;
      end else if (take) begin
         if (differs) begin
            done_o <= 1'b1;
            gt_o   <= (rel == REL_GT);
            lt_o   <= (rel == REL_LT);
         end else if (last) begin
            done_o <= 1'b1;
            eq_o   <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/smc_chk.sv
module smc_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              valid_i,
   input logic [BYTE_W-1:0] a_i,
   input logic [BYTE_W-1:0] b_i,
   input logic              done_o,
   input logic              gt_o,
   input logic              eq_o,
   input logic              lt_o
);
   a_r4_one_flag_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $onehot({gt_o, eq_o, lt_o}));

   a_r4_flags_low_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ({gt_o, eq_o, lt_o} == 3'b000));

   a_r5_done_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(valid_i) && !$past(start_i));

   a_r5_unequal_from_diff: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done_o) && !eq_o) |-> ($past(a_i) != $past(b_i)));

   a_r6_equal_from_match: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done_o) && eq_o) |-> ($past(a_i) == $past(b_i)));

   a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && !gt_o && !eq_o && !lt_o));

   a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable({gt_o, eq_o, lt_o})));
endmodule

bind serial_mag_cmp smc_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .valid_i(valid_i),
   .a_i    (a_i),
   .b_i    (b_i),
   .done_o (done_o),
   .gt_o   (gt_o),
   .eq_o   (eq_o),
   .lt_o   (lt_o)
);

// File: tb/tb_serial_mag_cmp.sv
module tb_serial_mag_cmp;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [3:0] nbytes_i = '0;
   logic       signed_i = 1'b0;
   logic       valid_i = 1'b0;
   logic [7:0] a_i = '0;
   logic [7:0] b_i = '0;
   logic       done_o, gt_o, eq_o, lt_o;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [2:0] flags;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   serial_mag_cmp dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .nbytes_i(nbytes_i),
      .signed_i(signed_i), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
      .done_o(done_o), .gt_o(gt_o), .eq_o(eq_o), .lt_o(lt_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference order of the N-byte operands, from the arithmetic value
   function automatic logic [2:0] ref_flags(input int n, input bit sg,
                                             input logic [63:0] a, input logic [63:0] b);
      logic [63:0] mask;
      longint sa, sb_v;
      mask = (n == 8) ? '1 : ((64'd1 << (8 * n)) - 64'd1);
      if (sg) begin
         sa   = longint'(a << (64 - 8 * n)) >>> (64 - 8 * n);
         sb_v = longint'(b << (64 - 8 * n)) >>> (64 - 8 * n);
         if (sa > sb_v) return 3'b100;
         if (sa < sb_v) return 3'b001;
         return 3'b010;
      end
      if ((a & mask) > (b & mask)) return 3'b100;
      if ((a & mask) < (b & mask)) return 3'b001;
      return 3'b010;
   endfunction

   // driver: pushes the expected result, streams bytes, checks done timing
   task automatic run_cmp(input int raw_n, input int n, input bit sg,
                          input logic [63:0] a, input logic [63:0] b,
                          input int extra, input bit gaps, input string tag);
      int decide;
      logic [2:0] expf;
      exp_t item;
      expf = ref_flags(n, sg, a, b);
      decide = n - 1;
      for (int k = n - 1; k >= 0; k--)
         if (a[8*k +: 8] != b[8*k +: 8]) begin decide = n - 1 - k; break; end
      item.flags = expf;
      item.tag = tag;
      sb.push_back(item);
      @(negedge clk);
      start_i = 1'b1; nbytes_i = 4'(raw_n); signed_i = sg;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0, "R7", {tag, " done low after start"}, done_o, 0);
      for (int k = 0; k < n + extra; k++) begin
         valid_i = 1'b1;
         if (k < n) begin
            a_i = a[8*(n-1-k) +: 8];
            b_i = b[8*(n-1-k) +: 8];
         end else begin
            a_i = 8'h11; b_i = 8'h22;
         end
         @(negedge clk);
         if (k < n || k == n + extra - 1)
            chk(done_o == (k >= decide), (k == decide) ? "R5/R6" : "R5",
                $sformatf("%s done after pair %0d", tag, k), done_o, (k >= decide));
         if (gaps) begin
            valid_i = 1'b0;
            @(negedge clk);
         end
      end
      valid_i = 1'b0;
      repeat (2) @(negedge clk);
      chk({gt_o, eq_o, lt_o} == expf && done_o, "R8", {tag, " result held"},
          {done_o, gt_o, eq_o, lt_o}, {1'b1, expf});
   endtask

   // monitor: on each rising done, compare with the oldest expected item
   initial begin
      logic prev;
      exp_t it;
      prev = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n && done_o && !prev) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R5", "unexpected done", 1, 0);
            end else begin
               it = sb.pop_front();
               chk({gt_o, eq_o, lt_o} == it.flags, "R4", {it.tag, " flags"},
                   {gt_o, eq_o, lt_o}, it.flags);
            end
         end
         prev = done_o;
      end
   end

   initial begin : main
      fork
         begin
            repeat (3) @(negedge clk);
            chk({done_o, gt_o, eq_o, lt_o} == 4'b0, "R4", "reset state",
                {done_o, gt_o, eq_o, lt_o}, 0);
            rst_n = 1'b1;
            // R10 / R1: unsigned, decided at the low byte
            run_cmp(2, 2, 0, 64'h1234, 64'h1235, 0, 0, "R10 2B lt");
            // R10: unsigned top bit set is larger; trailing pairs ignored (R5)
            run_cmp(4, 4, 0, 64'h80000000, 64'h7FFFFFFF, 3, 0, "R10 4B gt");
            // R2: same patterns, signed
            run_cmp(4, 4, 1, 64'h80000000, 64'h7FFFFFFF, 2, 0, "R2 4B lt");
            run_cmp(1, 1, 1, 64'h7F, 64'h80, 0, 0, "R2 1B gt");
            run_cmp(1, 1, 0, 64'h7F, 64'h80, 0, 0, "R10 1B lt");
            // R3: lower bytes unsigned in signed mode
            run_cmp(2, 2, 1, 64'h0180, 64'h0170, 0, 0, "R3 low gt");
            run_cmp(3, 3, 1, 64'hFF0001, 64'hFF00FF, 0, 1, "R3 low lt");
            // R1: top byte decides over opposite lower bytes
            run_cmp(3, 3, 0, 64'h01FFFF, 64'h020000, 2, 1, "R1 msb lt");
            // R6: 8 equal bytes with gaps
            run_cmp(8, 8, 1, 64'hDEADBEEF01234567, 64'hDEADBEEF01234567, 1, 1, "R6 8B eq");
            // R7: abort a live comparison, start with valid pair not consumed
            @(negedge clk);
            start_i = 1'b1; nbytes_i = 4'd4; signed_i = 1'b0;
            @(negedge clk);
            start_i = 1'b0;
            for (int k = 0; k < 2; k++) begin
               valid_i = 1'b1; a_i = 8'h55; b_i = 8'h55;
               @(negedge clk);
            end
            start_i = 1'b1; nbytes_i = 4'd2; valid_i = 1'b1; a_i = 8'h01; b_i = 8'h02;
            @(negedge clk);
            start_i = 1'b0; valid_i = 1'b0;
            chk(done_o == 1'b0, "R7", "abort: pair with start not consumed", done_o, 0);
            sb.push_back('{flags: 3'b010, tag: "R7 restart eq"});
            for (int k = 0; k < 2; k++) begin
               valid_i = 1'b1; a_i = 8'h3C; b_i = 8'h3C;
               @(negedge clk);
               chk(done_o == (k == 1), "R7", "restart counts two pairs", done_o, (k == 1));
            end
            valid_i = 1'b0;
            @(negedge clk);
            // R9: count 0 acts as 1; count 12 acts as 8
            run_cmp(0, 1, 0, 64'h05, 64'h05, 2, 0, "R9 zero count");
            run_cmp(12, 8, 0, 64'h0102030405060708, 64'h0102030405060708, 1, 0, "R9 big count");
            repeat (3) @(negedge clk);
            chk(sb.size() == 0, "R4", "all expected results seen", sb.size(), 0);
         end
         begin
            repeat (100000) @(negedge clk);
            chk(1'b0, "R4", "watchdog expired", 0, 1);
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule